// File: doc/BRIEF.md
# MSI Capture Ring Writer

This block turns each incoming message-signalled interrupt into a 16-byte record in a circular buffer in system memory. The message word goes into the low four bytes of the record, with its lowest byte at the lowest address. The other twelve bytes are written as zero. For each record it stores, the block issues one write request on a simple valid/ready memory port. It then moves a hardware-owned write offset forward by one record and wraps that offset at the end of the buffer.

Software sets the block up through a word-addressed register port. The control word holds a master enable, a full-detection enable, an interrupt enable, a stop-on-full enable and a two-bit buffer size code. Other registers hold the 64-bit buffer base, a read offset that software moves forward as it drains records, and the write offset, which software can only read. The interrupt line is raised while the block is enabled, interrupts are enabled and records are waiting. When the buffer fills, the block either drops new messages or overwrites the oldest record, depending on the stop-on-full enable. In both cases it sets a sticky full flag.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset, every register reads as zero, `irq_out` is low and `mem_req_valid` is low.
- R2: The register offsets are: control at 0, base high at 3, base low at 4, read offset at 5 and write offset at 6. Control bit 0 is enable, bit 1 is full detection, bit 3 is interrupt enable, bit 4 is stop-on-full and bits 9:8 are the size code. All of these read back as written, and every other control bit reads zero except the sticky flag. The read offset reads back with its low four bits forced to zero. Writes to offset 6 are ignored, and unmapped offsets read zero.
- R3: A message accepted while enabled produces one memory write. Its address is base plus the write offset masked to the ring size. Data bits 31:0 carry the message word and bits 127:32 are zero. The request stays valid and unchanged until `mem_req_ready`.
- R4: The ring size is 2^(code+15) bytes. The write offset advances by 16 for each stored record and wraps to 0 after offset size-16.
- R5: While enabled, `msg_ready` is low while a write request is outstanding. While disabled, `msg_ready` is high and messages are discarded, with no request and no change to the write offset.
- R6: The buffer is full when full detection is on and (write offset + 16) mod size equals the masked read offset. A message accepted when the buffer is full with stop-on-full set is dropped: no request is made, the offset does not change, and the sticky flag at control bit 16 is set.
- R7: When the buffer is full and stop-on-full is clear, the record is still written and the offset still advances, so the oldest record is overwritten. The sticky flag is set.
- R8: Writing control with bit 16 set clears the sticky flag. With full detection off, the buffer is never full and the flag stays clear.
- R9: `irq_out` is high exactly when enable, interrupt enable and (masked write offset differs from masked read offset) are all true.
- R10: The read offset is compared under the current size mask, so its bits above the ring size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 3 | Register word offset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| msg_valid | input | 1 | Incoming interrupt message present |
| msg_ready | output | 1 | Block can take a message |
| msg_data | input | 32 | Interrupt message word |
| mem_req_valid | output | 1 | Memory write request valid |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_addr | output | 64 | Byte address of the record |
| mem_req_data | output | 128 | Record contents, byte 0 in bits 7:0 |
| irq_out | output | 1 | Interrupt toward the host |

## Verification
The hardest states to reach from the ports are the wrap of the write offset and the full condition, because software cannot write the write offset directly. The stimulus drives the offset to the end of a 32 KB ring by sending exactly enough messages, working out the count from the offset read back through the register port, and then checks that the last record lands at base+0x7FF0 and that the offset returns to zero. The full cases are reached by placing the read offset three records ahead of the write offset. The bench then tries drop, overwrite and detection-off in turn, and reads back the sticky flag after each one.

// File: rtl/msi_ring_pkg.sv
`timescale 1ns/1ps
package msi_ring_pkg;

    localparam int CODE_W = 2;

    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_BASE_HI = 3'd3;
    localparam logic [2:0] REG_BASE_LO = 3'd4;
    localparam logic [2:0] REG_RD_OFF  = 3'd5;
    localparam logic [2:0] REG_WR_OFF  = 3'd6;

    localparam int BIT_EN     = 0;
    localparam int BIT_FDET   = 1;
    localparam int BIT_IRQ    = 3;
    localparam int BIT_STOP   = 4;
    localparam int BIT_SIZE   = 8;
    localparam int BIT_STICKY = 16;

    typedef struct packed {
        logic [CODE_W-1:0] size_code;
        logic              stop_en;
        logic              irq_en;
        logic              fdet_en;
        logic              enable;
    } ctrl_t;

    // Byte mask of a record offset inside a ring of 2^(code+min_shift) bytes.
    function automatic logic [31:0] ring_mask(input logic [CODE_W-1:0] code,
                                              input int min_shift);
        logic [31:0] sz;
        sz = 32'd1 << (min_shift + int'(code));
        return (sz - 32'd1) & ~32'hF;
    endfunction

endpackage

// File: rtl/msi_ring_regs.sv
`timescale 1ns/1ps
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int OFF_W  = 18,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic              full_hit,
    input  logic [OFF_W-1:0]  wr_off,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [OFF_W-1:0]  rd_off_q
);
    logic sticky_q;
    logic ctrl_wr;

    assign ctrl_wr = cfg_wr_en && (cfg_addr == REG_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            base_q   <= '0;
            rd_off_q <= '0;
            sticky_q <= 1'b0;
        end else begin
            if (cfg_wr_en) begin
                case (cfg_addr)
                    REG_CTRL: begin
                        ctrl_q.enable    <= cfg_wr_data[BIT_EN];
                        ctrl_q.fdet_en   <= cfg_wr_data[BIT_FDET];
                        ctrl_q.irq_en    <= cfg_wr_data[BIT_IRQ];
                        ctrl_q.stop_en   <= cfg_wr_data[BIT_STOP];
                        ctrl_q.size_code <= cfg_wr_data[BIT_SIZE +: CODE_W];
                    end
                    REG_BASE_HI: base_q[ADDR_W-1:32] <= cfg_wr_data[ADDR_W-33:0];
                    REG_BASE_LO: base_q[31:0]        <= cfg_wr_data;
                    REG_RD_OFF:  rd_off_q <= {cfg_wr_data[OFF_W-1:4], 4'h0};
                    default: ;
                endcase
            end
            if (full_hit)
                sticky_q <= 1'b1;
            else if (ctrl_wr && cfg_wr_data[BIT_STICKY])
                sticky_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rd_data = '0;
        case (cfg_addr)
            REG_CTRL: begin
                cfg_rd_data[BIT_EN]              = ctrl_q.enable;
                cfg_rd_data[BIT_FDET]            = ctrl_q.fdet_en;
                cfg_rd_data[BIT_IRQ]             = ctrl_q.irq_en;
                cfg_rd_data[BIT_STOP]            = ctrl_q.stop_en;
                cfg_rd_data[BIT_SIZE +: CODE_W]  = ctrl_q.size_code;
                cfg_rd_data[BIT_STICKY]          = sticky_q;
            end
            REG_BASE_HI: cfg_rd_data = base_q[ADDR_W-1:32];
            REG_BASE_LO: cfg_rd_data = base_q[31:0];
            REG_RD_OFF:  cfg_rd_data[OFF_W-1:0] = rd_off_q;
            REG_WR_OFF:  cfg_rd_data[OFF_W-1:0] = wr_off;
            default:     cfg_rd_data = '0;
        endcase
    end

endmodule

// File: rtl/msi_ring_engine.sv
`timescale 1ns/1ps
module msi_ring_engine
    import msi_ring_pkg::*;
#(
    parameter int OFF_W       = 18,
    parameter int ADDR_W      = 64,
    parameter int MIN_SHIFT   = 15,
    parameter int ENTRY_BYTES = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enable,
    input  logic                     fdet_en,
    input  logic                     stop_en,
    input  logic [CODE_W-1:0]        size_code,
    input  logic [ADDR_W-1:0]        base,
    input  logic [OFF_W-1:0]         rd_off,
    input  logic                     msg_valid,
    output logic                     msg_ready,
    input  logic [31:0]              msg_data,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [ADDR_W-1:0]        mem_req_addr,
    output logic [ENTRY_BYTES*8-1:0] mem_req_data,
    output logic [OFF_W-1:0]         wr_off,
    output logic [OFF_W-1:0]         wr_pos,
    output logic [OFF_W-1:0]         rd_pos,
    output logic                     full_hit
);
    localparam int ENTRY_W     = ENTRY_BYTES * 8;
    localparam int ENTRY_WORDS = ENTRY_BYTES / 4;

    logic [OFF_W-1:0]   mask;
    logic [OFF_W-1:0]   next_off;
    logic               is_full;
    logic               accept;
    logic               store;
    logic [ENTRY_W-1:0] record;

    assign mask     = OFF_W'(ring_mask(size_code, MIN_SHIFT));
    assign wr_pos   = wr_off & mask;
    assign rd_pos   = rd_off & mask;
    assign next_off = (wr_pos + OFF_W'(ENTRY_BYTES)) & mask;
    assign is_full  = fdet_en && (next_off == rd_pos);

    assign msg_ready = !enable || !mem_req_valid;
    assign accept    = msg_valid && msg_ready && enable;
    assign store     = accept && !(is_full && stop_en);
    assign full_hit  = accept && is_full;

    // Record layout: word 0 holds the message, remaining words are zero.
    for (genvar gi = 0; gi < ENTRY_WORDS; gi++) begin : g_word
        if (gi == 0) begin : g_msg
            assign record[31:0] = msg_data;
        end else begin : g_pad
            assign record[gi*32 +: 32] = 32'h0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_data  <= '0;
            wr_off        <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready)
                mem_req_valid <= 1'b0;
            if (store) begin
                mem_req_valid <= 1'b1;
                mem_req_addr  <= base + {{(ADDR_W-OFF_W){1'b0}}, wr_pos};
                mem_req_data  <= record;
                wr_off        <= next_off;
            end
        end
    end

endmodule

// File: rtl/msi_ring_irq.sv
`timescale 1ns/1ps
module msi_ring_irq #(
    parameter int OFF_W = 18
) (
    input  logic             enable,
    input  logic             irq_en,
    input  logic [OFF_W-1:0] wr_pos,
    input  logic [OFF_W-1:0] rd_pos,
    output logic             irq_out
);
    logic pending;

    assign pending = (wr_pos != rd_pos);
    assign irq_out = enable && irq_en && pending;

endmodule

// File: rtl/msi_ring_writer.sv
`timescale 1ns/1ps
module msi_ring_writer
    import msi_ring_pkg::*;
#(
    parameter int MIN_SHIFT   = 15,
    parameter int ADDR_W      = 64,
    parameter int ENTRY_BYTES = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               cfg_addr,
    input  logic                     cfg_wr_en,
    input  logic [31:0]              cfg_wr_data,
    output logic [31:0]              cfg_rd_data,
    input  logic                     msg_valid,
    output logic                     msg_ready,
    input  logic [31:0]              msg_data,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [ADDR_W-1:0]        mem_req_addr,
    output logic [ENTRY_BYTES*8-1:0] mem_req_data,
    output logic                     irq_out
);
    localparam int OFF_W = MIN_SHIFT + (1 << CODE_W) - 1;

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  rd_off_q;
    logic [OFF_W-1:0]  wr_off_q;
    logic [OFF_W-1:0]  wr_pos;
    logic [OFF_W-1:0]  rd_pos;
    logic              full_hit;

    msi_ring_regs #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_addr   (cfg_addr),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data),
        .full_hit   (full_hit),
        .wr_off     (wr_off_q),
        .ctrl_q     (ctrl_q),
        .base_q     (base_q),
        .rd_off_q   (rd_off_q)
    );

    msi_ring_engine #(
        .OFF_W(OFF_W), .ADDR_W(ADDR_W),
        .MIN_SHIFT(MIN_SHIFT), .ENTRY_BYTES(ENTRY_BYTES)
    ) engine_i (
        .clk          (clk),
        .rst          (rst),
        .enable       (ctrl_q.enable),
        .fdet_en      (ctrl_q.fdet_en),
        .stop_en      (ctrl_q.stop_en),
        .size_code    (ctrl_q.size_code),
        .base         (base_q),
        .rd_off       (rd_off_q),
        .msg_valid    (msg_valid),
        .msg_ready    (msg_ready),
        .msg_data     (msg_data),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_req_data (mem_req_data),
        .wr_off       (wr_off_q),
        .wr_pos       (wr_pos),
        .rd_pos       (rd_pos),
        .full_hit     (full_hit)
    );

    msi_ring_irq #(.OFF_W(OFF_W)) irq_i (
        .enable (ctrl_q.enable),
        .irq_en (ctrl_q.irq_en),
        .wr_pos (wr_pos),
        .rd_pos (rd_pos),
        .irq_out(irq_out)
    );

endmodule

// File: rtl/msi_ring_chk.sv
`timescale 1ns/1ps
module msi_ring_chk
    import msi_ring_pkg::*;
#(
    parameter int OFF_W     = 18,
    parameter int ADDR_W    = 64,
    parameter int MIN_SHIFT = 15,
    parameter int ENTRY_W   = 128
) (
    input logic               clk,
    input logic               rst,
    input ctrl_t              ctrl_q,
    input logic [OFF_W-1:0]   wr_off_q,
    input logic [OFF_W-1:0]   rd_off_q,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic [ENTRY_W-1:0] mem_req_data,
    input logic               irq_out
);
    logic [OFF_W-1:0] c_mask;
    logic [OFF_W-1:0] c_next;
    logic             c_full_stop;

    assign c_mask      = OFF_W'(ring_mask(ctrl_q.size_code, MIN_SHIFT));
    assign c_next      = ((wr_off_q & c_mask) + OFF_W'(16)) & c_mask;
    assign c_full_stop = ctrl_q.enable && ctrl_q.fdet_en && ctrl_q.stop_en
                         && (c_next == (rd_off_q & c_mask));

    // R3: an outstanding request holds its contents until taken
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

    // R4: the write offset only ever moves one record forward, modulo size
    assert_wr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_off_q != $past(wr_off_q)) |->
            (wr_off_q == ((($past(wr_off_q) & $past(c_mask)) + OFF_W'(16))
                          & $past(c_mask))));

    // R5: no new message is taken while a request is pending and enabled
    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.enable && mem_req_valid) |-> !msg_ready);

    // R6: a message hitting a full ring with stop set leaves no trace
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && c_full_stop && !mem_req_valid) |=>
            (!mem_req_valid && $stable(wr_off_q)));

    // R9: the interrupt never shows while the block or its interrupt is off
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable || !ctrl_q.irq_en) |-> !irq_out);

endmodule

bind msi_ring_writer msi_ring_chk #(
    .OFF_W(OFF_W), .ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .ENTRY_W(ENTRY_BYTES*8)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ctrl_q       (ctrl_q),
    .wr_off_q     (wr_off_q),
    .rd_off_q     (rd_off_q),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_req_data (mem_req_data),
    .irq_out      (irq_out)
);

// File: tb/msi_ring_writer_tb_top.sv
`timescale 1ns/1ps
module msi_ring_writer_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   cfg_addr = '0;
    logic         cfg_wr_en = 1'b0;
    logic [31:0]  cfg_wr_data = '0;
    logic [31:0]  cfg_rd_data;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [31:0]  msg_data = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b1;
    logic [63:0]  mem_req_addr;
    logic [127:0] mem_req_data;
    logic         irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int mem_count = 0;
    logic [63:0]  last_addr = '0;
    logic [127:0] last_data = '0;

    localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

    always #10 clk = ~clk;

    msi_ring_writer dut_i (
        .clk(clk), .rst(rst),
        .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .irq_out(irq_out)
    );

    always @(posedge clk) begin
        if (!rst && mem_req_valid && mem_req_ready) begin
            mem_count <= mem_count + 1;
            last_addr <= mem_req_addr;
            last_data <= mem_req_data;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wr_data = d; cfg_wr_en = 1'b1;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rd_data;
    endtask

    task automatic send_msg(input logic [31:0] d);
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        msg_valid = 1'b1; msg_data = d;
        @(posedge clk); #1;
        msg_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            cfg_read(3'(a), v);
            check("R1 reg reset", 128'(v), 128'h0);
        end
        check("R1 irq reset", 128'(irq_out), 128'h0);
        check("R1 req reset", 128'(mem_req_valid), 128'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        cfg_write(3'd0, 32'h0000_031B);
        settle(1); cfg_read(3'd0, v); check("R2 ctrl readback", 128'(v), 128'h31B);
        cfg_write(3'd0, 32'hFFFF_FCE4);
        settle(1); cfg_read(3'd0, v); check("R2 ctrl unused bits", 128'(v), 128'h0);
        cfg_write(3'd3, BASE[63:32]);
        cfg_write(3'd4, BASE[31:0]);
        settle(1);
        cfg_read(3'd3, v); check("R2 base hi", 128'(v), 128'(BASE[63:32]));
        cfg_read(3'd4, v); check("R2 base lo", 128'(v), 128'(BASE[31:0]));
        cfg_write(3'd5, 32'h0001_234F);
        settle(1); cfg_read(3'd5, v); check("R2 rd offset aligned", 128'(v), 128'h12340);
        cfg_write(3'd5, 32'h0);
        cfg_write(3'd6, 32'h50);
        settle(1); cfg_read(3'd6, v); check("R2 wr offset write ignored", 128'(v), 128'h0);
        cfg_read(3'd1, v); check("R2 unmapped reads zero", 128'(v), 128'h0);
    endtask

    task automatic t_store();
        logic [31:0] v;
        int base_cnt;
        cfg_write(3'd0, 32'h9);
        base_cnt = mem_count;
        send_msg(32'hDEAD_BEEF);
        settle(2);
        check("R3 one write", 128'(mem_count - base_cnt), 128'd1);
        check("R3 address", 128'(last_addr), 128'(BASE));
        check("R3 record data", last_data, 128'hDEAD_BEEF);
        cfg_read(3'd6, v); check("R4 offset step", 128'(v), 128'h10);
        check("R9 irq pending", 128'(irq_out), 128'h1);
        send_msg(32'h0000_1234);
        settle(2);
        check("R3 second address", 128'(last_addr), 128'(BASE + 64'h10));
        check("R3 second data", last_data, 128'h1234);
        cfg_write(3'd5, 32'h20);
        settle(1);
        check("R9 irq cleared by drain", 128'(irq_out), 128'h0);
    endtask

    task automatic t_backpressure();
        logic [31:0] v;
        int base_cnt;
        base_cnt = mem_count;
        mem_req_ready = 1'b0;
        send_msg(32'hCAFE_0001);
        settle(1);
        check("R3 request raised", 128'(mem_req_valid), 128'h1);
        check("R5 ready low while busy", 128'(msg_ready), 128'h0);
        cfg_read(3'd6, v); check("R4 offset after busy store", 128'(v), 128'h30);
        settle(3);
        check("R3 request held", 128'(mem_req_valid), 128'h1);
        check("R3 held address", 128'(mem_req_addr), 128'(BASE + 64'h20));
        mem_req_ready = 1'b1;
        settle(1);
        check("R3 single transfer", 128'(mem_count - base_cnt), 128'd1);
        check("R5 ready back", 128'(msg_ready), 128'h1);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int base_cnt;
        cfg_write(3'd0, 32'h8);
        settle(1);
        check("R9 irq off when disabled", 128'(irq_out), 128'h0);
        check("R5 ready while disabled", 128'(msg_ready), 128'h1);
        base_cnt = mem_count;
        send_msg(32'h0BAD_0BAD);
        settle(3);
        check("R5 disabled no write", 128'(mem_count - base_cnt), 128'd0);
        cfg_read(3'd6, v); check("R5 disabled offset kept", 128'(v), 128'h30);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int n;
        cfg_write(3'd0, 32'h1);
        settle(1);
        cfg_read(3'd6, v);
        n = (32'h8000 - int'(v)) / 16;
        for (int i = 0; i < n; i++) send_msg(32'(i));
        settle(2);
        check("R4 last record at ring end", 128'(last_addr), 128'(BASE + 64'h7FF0));
        cfg_read(3'd6, v); check("R4 offset wrapped", 128'(v), 128'h0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        int base_cnt;
        cfg_write(3'd5, 32'h30);
        cfg_write(3'd0, 32'h13);
        base_cnt = mem_count;
        send_msg(32'hA); send_msg(32'hB); send_msg(32'hC);
        settle(2);
        check("R6 drop when full", 128'(mem_count - base_cnt), 128'd2);
        cfg_read(3'd6, v); check("R6 offset held", 128'(v), 128'h20);
        cfg_read(3'd0, v); check("R6 sticky set", 128'(v), 128'h10013);
        cfg_write(3'd0, 32'h10013);
        settle(1); cfg_read(3'd0, v); check("R8 sticky cleared", 128'(v), 128'h13);
        cfg_write(3'd0, 32'h3);
        send_msg(32'hD);
        settle(2);
        check("R7 overwrite address", 128'(last_addr), 128'(BASE + 64'h20));
        cfg_read(3'd6, v); check("R7 offset advanced", 128'(v), 128'h30);
        cfg_read(3'd0, v); check("R7 sticky set", 128'(v), 128'h10003);
        cfg_write(3'd0, 32'h10001);
        cfg_write(3'd5, 32'h40);
        send_msg(32'hE);
        settle(2);
        check("R8 no detect still stores", 128'(last_addr), 128'(BASE + 64'h30));
        cfg_read(3'd0, v); check("R8 no sticky without detect", 128'(v), 128'h1);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        cfg_write(3'd0, 32'h9);
        cfg_write(3'd5, 32'h8040);
        settle(1);
        cfg_read(3'd5, v); check("R10 rd offset stored", 128'(v), 128'h8040);
        check("R10 high bits ignored", 128'(irq_out), 128'h0);
        cfg_write(3'd0, 32'h109);
        settle(1);
        check("R10 high bits count at 64KB", 128'(irq_out), 128'h1);
        send_msg(32'hF);
        settle(2);
        check("R4 store under 64KB", 128'(last_addr), 128'(BASE + 64'h40));
        cfg_read(3'd6, v); check("R4 offset under 64KB", 128'(v), 128'h50);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_store();
        t_backpressure();
        t_disabled();
        t_wrap();
        t_full();
        t_mask();
        settle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule